// File: doc/BRIEF.md
# Message-Signaled Interrupt File Controller

This block is the per-hart store of external interrupt identities. For every implemented identity it keeps one pending bit and one enable bit. Identities become pending either through a message-write port, which carries an identity number, or through software accesses to the pending array. The block selects the lowest-numbered identity that is both pending and enabled and reports it on a top-pending port. It raises the hart interrupt line when delivery is switched on and such an identity exists.

Software never addresses the arrays directly. It first loads a register number into a select register, and then uses a data port to read, write, bit-set or bit-clear the register that the select value names. A claim strobe on the top-pending port returns the current winner and clears that identity's pending bit in the same cycle, so two handlers cannot take the same interrupt. Delivery enable and a priority threshold are two more selectable registers.

Top module: `msif_file`

## Requirements
- R1: After reset all pending and enable bits are 0, delivery is off, the threshold is 0, the select register is 0, `irq` is low and `top_value` is 0.
- R2: `sel_we` loads `sel_wdata` into the select register at the clock edge. A data access in the same cycle as a select write acts on the select value held before that edge.
- R3: Select numbers 0x80+k (k = 0..63) name pending word k, where bit b holds identity 32k+b. `dat_rdata` shows the selected register's current value combinationally. When `dat_valid` is high, `dat_op` = 0 reads with no change, 1 writes `dat_wdata`, 2 ORs `dat_wdata` in and 3 clears the bits that are 1 in `dat_wdata`. The change is visible after the edge.
- R4: Select numbers 0xC0+k name enable word k. Bit layout and operations are the same as in R3.
- R5: Identity 0 and identities above `NUM_IDS` always read 0, in both arrays, and writes cannot set them. Select numbers that name no register read 0, and writes to them are ignored.
- R6: Select 0x70 is delivery enable, held in bit 0. Select 0x72 is the threshold, held in bits 10:0. Both take all four data operations.
- R7: `top_value` carries the lowest identity that is pending and enabled, in bits 26:16 and again in bits 10:0, with all other bits 0. When the threshold is nonzero, only identities numerically below it qualify. With no candidate, `top_value` is 0.
- R8: `top_claim` clears, at the edge, the pending bit of the identity `top_value` reports in that cycle. When `top_value` is 0 the claim has no effect. A claim is applied after a same-cycle data operation.
- R9: `msg_valid` sets the pending bit of `msg_id` at the edge. Identity 0 and identities above `NUM_IDS` are ignored.
- R10: If a claim and a message write target the same identity in one cycle, that identity remains pending.
- R11: `irq` is high exactly when delivery is on and `top_value` is nonzero.
- R12: A threshold of 1 masks every identity, which forces `top_value` to 0 and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | 8 | New select value |
| dat_valid | input | 1 | Data port access strobe |
| dat_op | input | 2 | 0 read, 1 write, 2 bit-set, 3 bit-clear |
| dat_wdata | input | 32 | Data port write value or bit mask |
| dat_rdata | output | 32 | Current value of the selected register |
| top_value | output | 32 | Winning identity in bits 26:16 and 10:0 |
| top_claim | input | 1 | Claim the reported identity |
| msg_valid | input | 1 | Message write strobe |
| msg_id | input | 11 | Identity carried by the message |
| irq | output | 1 | Interrupt request to the hart |

## Verification
The bound checker checks the following on every cycle:
- a legal message leaves its identity pending;
- an illegal message, with no other access in the same cycle, leaves the pending array unchanged;
- a claim clears the winner unless a message for the same identity arrives in that cycle;
- identity 0 never holds a bit;
- any reported winner really is pending and enabled;
- `irq` implies delivery and a nonzero winner;
- a threshold of 1 keeps `irq` low.

Other behaviours can only be shown by the bench's scenarios, which compare against a reference model: the choice of the lowest qualifying identity, the exact read-back of every register and of the unimplemented bits, the use of the old select value when a select write and a data access share a cycle, and the threshold boundary at which a value equal to the threshold is masked.

// File: rtl/msif_pkg.sv
package msif_pkg;
  localparam int DATA_W = 32;
  localparam int ID_W   = 11;
  localparam int SEL_W  = 8;
  localparam int WIDX_W = 6;

  localparam logic [SEL_W-1:0] SEL_DELIVER = 8'h70;
  localparam logic [SEL_W-1:0] SEL_THRESH  = 8'h72;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } dat_op_e;

  function automatic logic [DATA_W-1:0] apply_op(dat_op_e op,
                                                 logic [DATA_W-1:0] old,
                                                 logic [DATA_W-1:0] wd);
    case (op)
      OP_WRITE: apply_op = wd;
      OP_SET:   apply_op = old | wd;
      OP_CLEAR: apply_op = old & ~wd;
      default:  apply_op = old;
    endcase
  endfunction
endpackage

// File: rtl/msif_bitvec.sv
module msif_bitvec
  import msif_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int NWORDS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic [WIDX_W-1:0]        acc_idx,
  input  dat_op_e                  acc_op,
  input  logic [DATA_W-1:0]        acc_wdata,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     set_en,
  input  logic [ID_W-1:0]          set_id,
  input  logic                     clr_en,
  input  logic [ID_W-1:0]          clr_id,
  output logic [NWORDS*DATA_W-1:0] bits
);
  localparam int BIT_SEL_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] impl_mask(int w);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) begin
      m[b] = ((w * DATA_W + b) >= 1) && ((w * DATA_W + b) <= NUM_IDS);
    end
    return m;
  endfunction

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] IMPL = impl_mask(w);
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              acc_hit;
    logic              set_hit;
    logic              clr_hit;
    logic              word_upd;

    always_comb begin
      acc_hit  = acc_en && (acc_idx == WIDX_W'(w));
      set_hit  = set_en && (set_id[ID_W-1:BIT_SEL_W] == WIDX_W'(w));
      clr_hit  = clr_en && (clr_id[ID_W-1:BIT_SEL_W] == WIDX_W'(w));
      word_d   = word_q;
      if (acc_hit) begin
        word_d = apply_op(acc_op, word_q, acc_wdata);
      end
      if (clr_hit) begin
        word_d[clr_id[BIT_SEL_W-1:0]] = 1'b0;
      end
      if (set_hit) begin
        word_d[set_id[BIT_SEL_W-1:0]] = 1'b1;
      end
      word_d   = word_d & IMPL;
      word_upd = acc_hit || set_hit || clr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_upd) begin
        word_q <= word_d;
      end
    end

    assign bits[w*DATA_W +: DATA_W] = word_q;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (acc_idx == WIDX_W'(w)) begin
        rd_data = bits[w*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/msif_prio.sv
module msif_prio
  import msif_pkg::*;
#(
  parameter int NBITS = 64
) (
  input  logic [NBITS-1:0] cand,
  input  logic [ID_W-1:0]  thresh,
  output logic [ID_W-1:0]  win_id
);
  always_comb begin
    win_id = '0;
    for (int i = NBITS - 1; i >= 1; i--) begin
      if (cand[i] && ((thresh == '0) || (i < int'(thresh)))) begin
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/msif_ctrl.sv
module msif_ctrl
  import msif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [SEL_W-1:0] acc_sel,
  input  dat_op_e          acc_op,
  input  logic [ID_W-1:0]  acc_wdata,
  output logic             deliver,
  output logic [ID_W-1:0]  thresh
);
  logic            deliver_q, deliver_d, deliver_hit;
  logic [ID_W-1:0] thresh_q, thresh_d;
  logic            thresh_hit;

  always_comb begin
    deliver_hit = acc_en && (acc_sel == SEL_DELIVER);
    thresh_hit  = acc_en && (acc_sel == SEL_THRESH);
    deliver_d   = deliver_q;
    thresh_d    = thresh_q;
    case (acc_op)
      OP_WRITE: begin
        deliver_d = acc_wdata[0];
        thresh_d  = acc_wdata;
      end
      OP_SET: begin
        deliver_d = deliver_q | acc_wdata[0];
        thresh_d  = thresh_q | acc_wdata;
      end
      OP_CLEAR: begin
        deliver_d = deliver_q & ~acc_wdata[0];
        thresh_d  = thresh_q & ~acc_wdata;
      end
      default: begin
        deliver_d = deliver_q;
        thresh_d  = thresh_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliver_q <= 1'b0;
    end else if (deliver_hit) begin
      deliver_q <= deliver_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
    end else if (thresh_hit) begin
      thresh_q <= thresh_d;
    end
  end

  assign deliver = deliver_q;
  assign thresh  = thresh_q;
endmodule

// File: rtl/msif_file.sv
module msif_file
  import msif_pkg::*;
#(
  parameter int NUM_IDS = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic              dat_valid,
  input  logic [1:0]        dat_op,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic [DATA_W-1:0] top_value,
  input  logic              top_claim,
  input  logic              msg_valid,
  input  logic [ID_W-1:0]   msg_id,
  output logic              irq
);
  localparam int NWORDS = (NUM_IDS + DATA_W) / DATA_W;
  localparam int NBITS  = NWORDS * DATA_W;

  logic [SEL_W-1:0]  sel_q, sel_d;
  dat_op_e           op;
  logic              wr_access;
  logic              hit_pend, hit_en;
  logic [DATA_W-1:0] pend_rd, en_rd;
  logic [NBITS-1:0]  pend_bits, en_bits;
  logic [ID_W-1:0]   top_id;
  logic [ID_W-1:0]   thresh_q;
  logic              deliver_q;
  logic              claim_en;

  always_comb begin
    sel_d = sel_we ? sel_wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  assign op        = dat_op_e'(dat_op);
  assign wr_access = dat_valid && (op != OP_READ);
  assign hit_pend  = (sel_q[SEL_W-1:SEL_W-2] == 2'b10);
  assign hit_en    = (sel_q[SEL_W-1:SEL_W-2] == 2'b11);
  assign claim_en  = top_claim && (top_id != '0);

  msif_bitvec #(.NUM_IDS(NUM_IDS), .NWORDS(NWORDS)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (wr_access && hit_pend),
    .acc_idx   (sel_q[WIDX_W-1:0]),
    .acc_op    (op),
    .acc_wdata (dat_wdata),
    .rd_data   (pend_rd),
    .set_en    (msg_valid),
    .set_id    (msg_id),
    .clr_en    (claim_en),
    .clr_id    (top_id),
    .bits      (pend_bits)
  );

  msif_bitvec #(.NUM_IDS(NUM_IDS), .NWORDS(NWORDS)) u_enab (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (wr_access && hit_en),
    .acc_idx   (sel_q[WIDX_W-1:0]),
    .acc_op    (op),
    .acc_wdata (dat_wdata),
    .rd_data   (en_rd),
    .set_en    (1'b0),
    .set_id    ('0),
    .clr_en    (1'b0),
    .clr_id    ('0),
    .bits      (en_bits)
  );

  msif_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (wr_access),
    .acc_sel   (sel_q),
    .acc_op    (op),
    .acc_wdata (dat_wdata[ID_W-1:0]),
    .deliver   (deliver_q),
    .thresh    (thresh_q)
  );

  msif_prio #(.NBITS(NBITS)) u_prio (
    .cand   (pend_bits & en_bits),
    .thresh (thresh_q),
    .win_id (top_id)
  );

  always_comb begin
    if (sel_q == SEL_DELIVER) begin
      dat_rdata = {{(DATA_W-1){1'b0}}, deliver_q};
    end else if (sel_q == SEL_THRESH) begin
      dat_rdata = {{(DATA_W-ID_W){1'b0}}, thresh_q};
    end else if (hit_pend) begin
      dat_rdata = pend_rd;
    end else if (hit_en) begin
      dat_rdata = en_rd;
    end else begin
      dat_rdata = '0;
    end
  end

  assign top_value = {5'b0, top_id, 5'b0, top_id};
  assign irq       = deliver_q && (top_id != '0);
endmodule

// File: rtl/msif_file_chk.sv
module msif_file_chk
  import msif_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int NBITS   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dat_valid,
  input logic              top_claim,
  input logic              msg_valid,
  input logic [ID_W-1:0]   msg_id,
  input logic [DATA_W-1:0] top_value,
  input logic              irq,
  input logic [NBITS-1:0]  pend_bits,
  input logic [NBITS-1:0]  en_bits,
  input logic [ID_W-1:0]   top_id,
  input logic [ID_W-1:0]   thresh_q,
  input logic              deliver_q
);
  localparam logic [NBITS-1:0] ONE = {{(NBITS-1){1'b0}}, 1'b1};

  logic msg_ok;
  assign msg_ok = (msg_id != '0) && (int'(msg_id) <= NUM_IDS);

  p_msg_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ok) |=> ((pend_bits & (ONE << $past(msg_id))) != '0));

  p_bad_msg_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ok && !dat_valid && !top_claim) |=> $stable(pend_bits));

  p_claim_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (top_claim && (top_id != '0) && !(msg_valid && (msg_id == top_id)))
      |=> ((pend_bits & (ONE << $past(top_id))) == '0));

  p_claim_msg_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (top_claim && (top_id != '0) && msg_valid && (msg_id == top_id))
      |=> ((pend_bits & (ONE << $past(top_id))) != '0));

  p_id0_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_bits[0] && !en_bits[0]);

  p_top_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_id != '0) |-> (((pend_bits & en_bits) & (ONE << top_id)) != '0));

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (deliver_q && (top_value[26:16] != '0)));

  p_thresh_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh_q == ID_W'(1)) |-> (!irq && (top_value == '0)));
endmodule

bind msif_file msif_file_chk #(.NUM_IDS(NUM_IDS), .NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dat_valid (dat_valid),
  .top_claim (top_claim),
  .msg_valid (msg_valid),
  .msg_id    (msg_id),
  .top_value (top_value),
  .irq       (irq),
  .pend_bits (pend_bits),
  .en_bits   (en_bits),
  .top_id    (top_id),
  .thresh_q  (thresh_q),
  .deliver_q (deliver_q)
);

// File: tb/msif_file_bench.sv
`timescale 1ns/1ps
module msif_file_bench;
  localparam int NUM = 63;
  localparam int NW  = (NUM + 32) / 32;
  localparam int NB  = NW * 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_we;
  logic [7:0]  sel_wdata;
  logic        dat_valid;
  logic [1:0]  dat_op;
  logic [31:0] dat_wdata;
  logic [31:0] dat_rdata;
  logic [31:0] top_value;
  logic        top_claim;
  logic        msg_valid;
  logic [10:0] msg_id;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NB-1:0] m_pend, m_en;
  logic [7:0]    m_sel;
  logic          m_deliv;
  logic [10:0]   m_thr;

  always #4 clk = ~clk;

  msif_file #(.NUM_IDS(NUM)) u_msif_file (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .dat_valid(dat_valid), .dat_op(dat_op), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .top_value(top_value), .top_claim(top_claim),
    .msg_valid(msg_valid), .msg_id(msg_id), .irq(irq)
  );

  function automatic logic [10:0] exp_top();
    for (int i = 1; i <= NUM; i++) begin
      if (m_pend[i] && m_en[i] && ((m_thr == 0) || (i < int'(m_thr)))) return 11'(i);
    end
    return 11'd0;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] s);
    if (s == 8'h70) return {31'b0, m_deliv};
    if (s == 8'h72) return {21'b0, m_thr};
    if (s[7:6] == 2'b10 && int'(s[5:0]) < NW) return m_pend[int'(s[5:0])*32 +: 32];
    if (s[7:6] == 2'b11 && int'(s[5:0]) < NW) return m_en[int'(s[5:0])*32 +: 32];
    return 32'd0;
  endfunction

  function automatic logic [31:0] op_apply(logic [1:0] o, logic [31:0] a, logic [31:0] w);
    case (o)
      2'd1: return w;
      2'd2: return a | w;
      2'd3: return a & ~w;
      default: return a;
    endcase
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_we = 0; sel_wdata = 0; dat_valid = 0; dat_op = 0; dat_wdata = 0;
    top_claim = 0; msg_valid = 0; msg_id = 0;
  endtask

  task automatic model_reset();
    m_pend = '0; m_en = '0; m_sel = 0; m_deliv = 0; m_thr = 0;
  endtask

  task automatic cycle(string rtag);
    logic [10:0] t;
    logic [31:0] v;
    #1;
    t = exp_top();
    chk(dat_rdata, exp_read(m_sel), rtag);
    chk(top_value, {5'b0, t, 5'b0, t}, "R7");
    chk({31'b0, irq}, {31'b0, m_deliv && (t != 0)}, "R11");
    @(posedge clk);
    if (dat_valid && dat_op != 2'd0) begin
      if (m_sel == 8'h70) begin
        v = op_apply(dat_op, {31'b0, m_deliv}, dat_wdata);
        m_deliv = v[0];
      end else if (m_sel == 8'h72) begin
        v = op_apply(dat_op, {21'b0, m_thr}, dat_wdata);
        m_thr = v[10:0];
      end else if (m_sel[7:6] == 2'b10 && int'(m_sel[5:0]) < NW) begin
        m_pend[int'(m_sel[5:0])*32 +: 32] =
          op_apply(dat_op, m_pend[int'(m_sel[5:0])*32 +: 32], dat_wdata);
      end else if (m_sel[7:6] == 2'b11 && int'(m_sel[5:0]) < NW) begin
        m_en[int'(m_sel[5:0])*32 +: 32] =
          op_apply(dat_op, m_en[int'(m_sel[5:0])*32 +: 32], dat_wdata);
      end
    end
    if (top_claim && t != 0) m_pend[t] = 1'b0;
    if (msg_valid && msg_id != 0 && int'(msg_id) <= NUM) m_pend[msg_id] = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (i == 0 || i > NUM) begin
        m_pend[i] = 1'b0;
        m_en[i] = 1'b0;
      end
    end
    if (sel_we) m_sel = sel_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic sel_to(logic [7:0] s);
    sel_we = 1; sel_wdata = s; cycle("R2");
  endtask

  task automatic dwr(logic [1:0] o, logic [31:0] w, string tag);
    dat_valid = 1; dat_op = o; dat_wdata = w; cycle(tag);
  endtask

  task automatic rdchk(logic [31:0] exp, string tag);
    #1 chk(dat_rdata, exp, tag);
  endtask

  task automatic topchk(int id, string tag);
    #1 chk(top_value, {5'b0, 11'(id), 5'b0, 11'(id)}, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] picks [8];
    void'($urandom(32'd24680));
    picks = '{8'h70, 8'h72, 8'h80, 8'h81, 8'h82, 8'hC0, 8'hC1, 8'h55};
    idle();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk(top_value, 0, "R1");
    chk({31'b0, irq}, 0, "R1");
    sel_to(8'hC1); rdchk(0, "R1");
    sel_to(8'h72); rdchk(0, "R1");
    // R4 and R5: enable arrays, id 0 and missing words
    sel_to(8'hC0); dwr(2'd1, 32'hFFFF_FFFF, "R4"); rdchk(32'hFFFF_FFFE, "R5");
    sel_to(8'hC1); dwr(2'd1, 32'hFFFF_FFFF, "R4"); rdchk(32'hFFFF_FFFF, "R4");
    sel_to(8'hC2); dwr(2'd1, 32'hFFFF_FFFF, "R5"); rdchk(0, "R5");
    sel_to(8'h33); dwr(2'd1, 32'hFFFF_FFFF, "R5"); rdchk(0, "R5");
    // R3 pending set, R7 lowest wins
    sel_to(8'h80); dwr(2'd2, 32'h0000_0120, "R3"); rdchk(32'h120, "R3");
    topchk(5, "R7");
    #1 chk({31'b0, irq}, 0, "R11");
    sel_to(8'h70); dwr(2'd1, 1, "R6"); rdchk(1, "R6");
    #1 chk({31'b0, irq}, 1, "R11");
    // R8 claim
    top_claim = 1; cycle("R8"); topchk(8, "R8");
    sel_to(8'hC0); dwr(2'd3, 32'h100, "R4"); topchk(0, "R4");
    dwr(2'd2, 32'h100, "R4"); topchk(8, "R4");
    // R10 claim and message on same identity
    top_claim = 1; msg_valid = 1; msg_id = 11'd8; cycle("R10"); topchk(8, "R10");
    // R9 illegal messages
    msg_valid = 1; msg_id = 11'd0; cycle("R9");
    msg_valid = 1; msg_id = 11'd64; cycle("R9");
    msg_valid = 1; msg_id = 11'd2000; cycle("R9");
    sel_to(8'h80); rdchk(32'h100, "R9");
    sel_to(8'h81); rdchk(0, "R9");
    msg_valid = 1; msg_id = 11'd40; cycle("R9"); rdchk(32'h100, "R9");
    // R6 threshold boundary, R12 threshold one
    sel_to(8'h72); dwr(2'd1, 8, "R6"); topchk(0, "R6");
    dwr(2'd1, 9, "R6"); topchk(8, "R6");
    dwr(2'd1, 1, "R12"); rdchk(1, "R6"); topchk(0, "R12");
    #1 chk({31'b0, irq}, 0, "R12");
    dwr(2'd1, 0, "R6"); topchk(8, "R6");
    // R2 select write and data access in one cycle
    sel_we = 1; sel_wdata = 8'h80; dat_valid = 1; dat_op = 2'd1; dat_wdata = 5; cycle("R2");
    rdchk(32'h100, "R2");
    sel_to(8'h72); rdchk(5, "R2");
    dwr(2'd1, 0, "R6");
    // R8 claim with nothing to claim
    sel_to(8'hC0); dwr(2'd1, 0, "R4"); sel_to(8'hC1); dwr(2'd1, 0, "R4");
    top_claim = 1; cycle("R8");
    sel_to(8'h80); rdchk(32'h100, "R8");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      sel_we = ($urandom % 4) == 0;
      sel_wdata = picks[$urandom % 8];
      dat_valid = $urandom % 2;
      dat_op = 2'($urandom % 4);
      dat_wdata = $urandom & $urandom;
      if (m_sel == 8'h72) dat_wdata = $urandom % 70;
      top_claim = ($urandom % 5) == 0;
      msg_valid = ($urandom % 3) == 0;
      msg_id = 11'($urandom % 80);
      cycle("R3");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule